// File: doc/BRIEF.md
# Clock/CMOS Host Register Port with Interrupt Flags

This block gives a host a byte-wide, two-address window onto a 128-byte register space for a real-time clock with battery-backed scratch storage. An address-0 write picks a register number; address-1 accesses then read or write the chosen register. Most of the space is plain storage. Four control locations at numbers 10 to 13 behave differently: a clock configuration register, a mode register, a status-flag register that clears when read, and a fixed status byte. The block drives a level interrupt line, and only a read of the flag register lowers it.

Time counting and the periodic rate divider live outside the block. The block starts a second update when an external one-second strobe arrives and the oscillator field allows it. It pulses `adv_time` so that the external counter advances. A fixed number of cycles later it copies the counter's fields into the visible time registers, compares the alarm bytes and raises the flags. A host write to a time register while updates run produces a `load_time` pulse, so the external counter can take the new value from `shadow_time`. The periodic divider reads its rate and enable from the block and returns a strobe on `periodic_tick`.

Top module: `cmos_host_regs`

## Requirements
- R1: A write with `bus_addr0`=0 loads the register number from `bus_wdata[6:0]` (bit 7 is dropped). A read with `bus_addr0`=0 returns 0xFF.
- R2: Accesses with `bus_addr0`=1 read or write the selected register. Every number other than 10 to 13 holds the last byte written to it. Read data is combinational in the cycle `bus_sel` is high.
- R3: In register 10, bits 6:0 take the written value. Bit 7 (update in progress) is read-only, and a write keeps its current value.
- R4: Writing register 11 with bit 7 (SET) high stores the value with bit 4 forced to 0, and it clears register 10 bit 7.
- R5: Writes to registers 12 and 13 have no effect. A read of register 12 returns its value, then clears it to 0x00 and lowers `irq` at the same clock edge.
- R6: After reset, registers 10, 11, 12 and 13 read 0x26, 0x02, 0x00 and 0x80. `irq` is low and the register number is 0.
- R7: At the end of an update, when register 11 bit 5 is set, the alarm bytes at registers 1, 3 and 5 are compared with the seconds, minutes and hours fields. A byte with bits 7:6 = 11 always matches. A match on all three sets register 12 bits 7 and 5 and raises `irq`.
- R8: Every update end sets register 12 bit 4. When register 11 bit 4 is set, it also sets bit 7 and raises `irq`.
- R9: A `sec_tick` starts an update only when register 10 bits 6:4 equal 010 and no update is running. A start gives a one-cycle `adv_time` pulse after the edge that samples the tick.
- R10: When SET is low, the update end copies the bytes of `now_fields` into registers 0, 2, 4, 6, 7, 8 and 9. The field order in `now_fields` is: byte 0 seconds, byte 1 minutes, byte 2 hours, byte 3 weekday, byte 4 day of month, byte 5 month, byte 6 year. When SET is high, the time registers keep their values.
- R11: Register 10 bit 7 reads 1 from the edge that starts an update through the UPD_CYCLES-th edge after it, then reads 0. It is never set by an update that starts with SET high.
- R12: `load_time` is high for one cycle after either of two writes. The first is a write to a time register (0, 2, 4, 6, 7, 8, 9) while SET is low. The second is a write to register 11 that clears a SET bit that was high. `shadow_time` shows the time registers in the `now_fields` byte order.
- R13: With register 11 bit 6 set, `periodic_tick` sets register 12 bits 7 and 6 and raises `irq`; with bit 6 clear the tick changes nothing. `rate_code` equals register 10 bits 3:0. `periodic_en` is high when `rate_code` is nonzero and register 11 bit 6 or bit 3 is set.
- R14: Flags raised at the same edge as a register-12 read survive. The read returns the old value, register 12 then holds the new flags, and `irq` stays high if any new flag raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr0 | input | 1 | 0 = register-number port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sec_tick | input | 1 | One-second strobe from the timebase |
| periodic_tick | input | 1 | Strobe from the external periodic divider |
| now_fields | input | 56 | Current time fields from the external counter |
| adv_time | output | 1 | Advance the external time counter |
| load_time | output | 1 | Host changed the time registers |
| shadow_time | output | 56 | Visible time registers, same byte order as now_fields |
| rate_code | output | 4 | Periodic rate selection |
| periodic_en | output | 1 | Periodic divider enable |
| irq | output | 1 | Level interrupt request |

## Verification
Two events can meet in one cycle: the clear-on-read of the flag register, and the flag raise at the end of a second update (or from a periodic strobe). The bench first leaves periodic flags pending. It then places a data-port read of register 12 exactly in the cycle whose closing edge ends a started update. It judges the outcome at the ports. The colliding read must return only the earlier flags, and `irq` must stay high. A second read must return the update-end and interrupt flags without the periodic flag.

// File: rtl/rtcr_pkg.sv
// Shared constants for the clock/CMOS host register block: register
// numbers, bit positions inside the control registers, reset values
// and the map from time field order to register number.
package rtcr_pkg;

    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 7;
    localparam int SPACE    = 1 << IDX_W;
    localparam int NUM_TIME = 7;
    localparam int NUM_ALM  = 3;

    localparam logic [IDX_W-1:0] IDX_CFG   = 7'd10;
    localparam logic [IDX_W-1:0] IDX_MODE  = 7'd11;
    localparam logic [IDX_W-1:0] IDX_FLAGS = 7'd12;
    localparam logic [IDX_W-1:0] IDX_STAT  = 7'd13;

    localparam logic [BYTE_W-1:0] CFG_RST   = 8'h26;
    localparam logic [BYTE_W-1:0] MODE_RST  = 8'h02;
    localparam logic [BYTE_W-1:0] FLAGS_RST = 8'h00;
    localparam logic [BYTE_W-1:0] STAT_VAL  = 8'h80;

    localparam int CFG_BUSY = 7;
    localparam int M_SET    = 7;
    localparam int M_PIE    = 6;
    localparam int M_AIE    = 5;
    localparam int M_UIE    = 4;
    localparam int M_SQW    = 3;
    localparam int F_IRQ    = 7;
    localparam int F_PER    = 6;
    localparam int F_ALM    = 5;
    localparam int F_UPD    = 4;

    localparam logic [2:0] OSC_RUN = 3'b010;

    // Register number of time field k (0 seconds ... 6 year).
    function automatic logic [IDX_W-1:0] time_slot(input int k);
        case (k)
            0:       time_slot = 7'd0;
            1:       time_slot = 7'd2;
            2:       time_slot = 7'd4;
            3:       time_slot = 7'd6;
            4:       time_slot = 7'd7;
            5:       time_slot = 7'd8;
            default: time_slot = 7'd9;
        endcase
    endfunction

    // Register number of alarm byte k (0 seconds, 1 minutes, 2 hours).
    function automatic logic [IDX_W-1:0] alarm_slot(input int k);
        alarm_slot = IDX_W'(2 * k + 1);
    endfunction

    // True when a register number belongs to a time field.
    function automatic logic is_time_idx(input logic [IDX_W-1:0] i);
        is_time_idx = 1'b0;
        for (int k = 0; k < NUM_TIME; k++) begin
            if (i == time_slot(k)) is_time_idx = 1'b1;
        end
    endfunction

endpackage

// File: rtl/rtcr_host_port.sv
// Host side of the two-address window. Holds the register number and
// turns bus strobes into single-cycle data write/read strobes.
// Assumes bus_sel is high for exactly one cycle per access.
module rtcr_host_port
    import rtcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr0,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [IDX_W-1:0]  idx_q,
    output logic              data_wr,
    output logic              data_rd
);

    assign data_wr = bus_sel && bus_wr && bus_addr0;
    assign data_rd = bus_sel && !bus_wr && bus_addr0;

    // Capture the register number; bit 7 of the write data is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (bus_sel && bus_wr && !bus_addr0) begin
            idx_q <= bus_wdata[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/rtcr_update_seq.sv
// Second-update sequencer. Starts on a one-second strobe when the
// oscillator field allows it, runs for UPD_CYCLES clocks, then
// signals the end of the update for one cycle.
// Assumes strobes arriving while an update runs may be dropped.
module rtcr_update_seq #(
    parameter int UPD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic osc_run,
    output logic upd_start,
    output logic upd_done,
    output logic busy,
    output logic adv_time
);

    localparam int CNT_W = (UPD_CYCLES > 1) ? $clog2(UPD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UPD_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign upd_start = sec_tick && osc_run && !busy;
    assign upd_done  = busy && (cnt == LAST);

    // Track the update window with a cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (upd_start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (upd_done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end

    // One-cycle advance pulse to the external time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) adv_time <= 1'b0;
        else        adv_time <= upd_start;
    end

endmodule

// File: rtl/rtcr_alarm_match.sv
// Alarm comparator. Each alarm byte matches its time field when equal,
// or always when its two top bits are both set.
// Assumes both buses carry bytes in the same field order.
module rtcr_alarm_match
    import rtcr_pkg::*;
#(
    parameter int N = NUM_ALM
) (
    input  logic [N*BYTE_W-1:0] alarm_bytes,
    input  logic [N*BYTE_W-1:0] now_bytes,
    output logic                hit
);

    logic [N-1:0] field_ok;

    for (genvar k = 0; k < N; k++) begin : g_field
        logic [BYTE_W-1:0] al;
        assign al          = alarm_bytes[k*BYTE_W +: BYTE_W];
        assign field_ok[k] = (&al[BYTE_W-1 -: 2]) ||
                             (al == now_bytes[k*BYTE_W +: BYTE_W]);
    end

    assign hit = &field_ok;

endmodule

// File: rtl/rtcr_ctrl_regs.sv
// Control registers: configuration (busy bit read-only), mode (SET
// forces the update-interrupt enable low), clear-on-read flags and the
// level interrupt line.
// Assumes at most one of wr_cfg, wr_mode, rd_flags is high per cycle.
module rtcr_ctrl_regs
    import rtcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cfg,
    input  logic              wr_mode,
    input  logic              rd_flags,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              upd_start,
    input  logic              upd_done,
    input  logic              alarm_hit,
    input  logic              periodic_tick,
    output logic [BYTE_W-1:0] reg_cfg,
    output logic [BYTE_W-1:0] reg_mode,
    output logic [BYTE_W-1:0] reg_flags,
    output logic              irq
);

    logic [BYTE_W-1:0] raise;
    logic              set_wr;

    assign set_wr = wr_mode && wdata[M_SET];

    // Gather the flags that events raise in this cycle.
    always_comb begin
        raise = '0;
        if (upd_done) begin
            raise[F_UPD] = 1'b1;
            if (reg_mode[M_UIE]) raise[F_IRQ] = 1'b1;
            if (reg_mode[M_AIE] && alarm_hit) begin
                raise[F_IRQ] = 1'b1;
                raise[F_ALM] = 1'b1;
            end
        end
        if (periodic_tick && reg_mode[M_PIE]) begin
            raise[F_IRQ] = 1'b1;
            raise[F_PER] = 1'b1;
        end
    end

    // Configuration register: low bits from the host, busy bit from updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_cfg <= CFG_RST;
        end else begin
            if (wr_cfg) reg_cfg[CFG_BUSY-1:0] <= wdata[CFG_BUSY-1:0];
            if (set_wr || upd_done)                 reg_cfg[CFG_BUSY] <= 1'b0;
            else if (upd_start && !reg_mode[M_SET]) reg_cfg[CFG_BUSY] <= 1'b1;
        end
    end

    // Mode register: SET writes store the update enable as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_mode <= MODE_RST;
        end else if (wr_mode) begin
            reg_mode        <= wdata;
            if (wdata[M_SET]) reg_mode[M_UIE] <= 1'b0;
        end
    end

    // Flag register: a read clears, new flags of the same edge survive.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_flags <= FLAGS_RST;
        else        reg_flags <= (rd_flags ? '0 : reg_flags) | raise;
    end

    // Interrupt line: raise wins over the clear of a coincident read.
    always_ff @(posedge clk) begin
        if (!rst_n)            irq <= 1'b0;
        else if (raise[F_IRQ]) irq <= 1'b1;
        else if (rd_flags)     irq <= 1'b0;
    end

endmodule

// File: rtl/cmos_host_regs.sv
// Top of the clock/CMOS host register block. Owns the plain byte
// storage and the read mux, and joins the host port, the update
// sequencer, the alarm comparator and the control registers.
// Assumes now_fields is stable during the update-end cycle.
module cmos_host_regs
    import rtcr_pkg::*;
#(
    parameter int UPD_CYCLES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic                       bus_addr0,
    input  logic [BYTE_W-1:0]          bus_wdata,
    output logic [BYTE_W-1:0]          bus_rdata,
    input  logic                       sec_tick,
    input  logic                       periodic_tick,
    input  logic [NUM_TIME*BYTE_W-1:0] now_fields,
    output logic                       adv_time,
    output logic                       load_time,
    output logic [NUM_TIME*BYTE_W-1:0] shadow_time,
    output logic [3:0]                 rate_code,
    output logic                       periodic_en,
    output logic                       irq
);

    logic [IDX_W-1:0]  idx_q;
    logic              data_wr, data_rd;
    logic              is_ctl;
    logic              wr_cfg, wr_mode, rd_flags;
    logic              upd_start, upd_done, busy, alarm_hit;
    logic [BYTE_W-1:0] reg_cfg, reg_mode, reg_flags;
    logic [BYTE_W-1:0] sel_byte;
    logic [NUM_ALM*BYTE_W-1:0] alarm_bytes;
    logic [BYTE_W-1:0] mem [SPACE];

    assign is_ctl   = (idx_q >= IDX_CFG) && (idx_q <= IDX_STAT);
    assign wr_cfg   = data_wr && (idx_q == IDX_CFG);
    assign wr_mode  = data_wr && (idx_q == IDX_MODE);
    assign rd_flags = data_rd && (idx_q == IDX_FLAGS);

    rtcr_host_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr0 (bus_addr0),
        .bus_wdata (bus_wdata),
        .idx_q     (idx_q),
        .data_wr   (data_wr),
        .data_rd   (data_rd)
    );

    rtcr_update_seq #(.UPD_CYCLES(UPD_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .osc_run   (reg_cfg[6:4] == OSC_RUN),
        .upd_start (upd_start),
        .upd_done  (upd_done),
        .busy      (busy),
        .adv_time  (adv_time)
    );

    for (genvar k = 0; k < NUM_ALM; k++) begin : g_alarm
        localparam logic [IDX_W-1:0] SLOT = alarm_slot(k);
        assign alarm_bytes[k*BYTE_W +: BYTE_W] = mem[SLOT];
    end

    rtcr_alarm_match #(.N(NUM_ALM)) u_alarm (
        .alarm_bytes (alarm_bytes),
        .now_bytes   (now_fields[NUM_ALM*BYTE_W-1:0]),
        .hit         (alarm_hit)
    );

    rtcr_ctrl_regs u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_cfg        (wr_cfg),
        .wr_mode       (wr_mode),
        .rd_flags      (rd_flags),
        .wdata         (bus_wdata),
        .upd_start     (upd_start),
        .upd_done      (upd_done),
        .alarm_hit     (alarm_hit),
        .periodic_tick (periodic_tick),
        .reg_cfg       (reg_cfg),
        .reg_mode      (reg_mode),
        .reg_flags     (reg_flags),
        .irq           (irq)
    );

    // Plain storage: host writes, then time refresh at update end.
    always_ff @(posedge clk) begin
        if (data_wr && !is_ctl) mem[idx_q] <= bus_wdata;
        if (upd_done && !reg_mode[M_SET]) begin
            for (int k = 0; k < NUM_TIME; k++) begin
                mem[time_slot(k)] <= now_fields[k*BYTE_W +: BYTE_W];
            end
        end
    end

    // Tell the external counter that the host changed the time.
    always_ff @(posedge clk) begin
        if (!rst_n) load_time <= 1'b0;
        else        load_time <= (data_wr && is_time_idx(idx_q) && !reg_mode[M_SET]) ||
                                 (wr_mode && !bus_wdata[M_SET] && reg_mode[M_SET]);
    end

    for (genvar k = 0; k < NUM_TIME; k++) begin : g_shadow
        localparam logic [IDX_W-1:0] SLOT = time_slot(k);
        assign shadow_time[k*BYTE_W +: BYTE_W] = mem[SLOT];
    end

    // Select the byte addressed by the register number.
    always_comb begin
        case (idx_q)
            IDX_CFG:   sel_byte = reg_cfg;
            IDX_MODE:  sel_byte = reg_mode;
            IDX_FLAGS: sel_byte = reg_flags;
            IDX_STAT:  sel_byte = STAT_VAL;
            default:   sel_byte = mem[idx_q];
        endcase
    end

    assign bus_rdata   = bus_addr0 ? sel_byte : 8'hFF;
    assign rate_code   = reg_cfg[3:0];
    assign periodic_en = (rate_code != 4'd0) && (reg_mode[M_PIE] || reg_mode[M_SQW]);

endmodule

// File: rtl/rtcr_checker.sv
// Property checker for cmos_host_regs, attached with bind below.
// Watches the control registers against the strobes that move them.
module rtcr_checker
    import rtcr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_cfg,
    input logic              wr_mode,
    input logic              rd_flags,
    input logic [BYTE_W-1:0] wdata,
    input logic              upd_start,
    input logic              upd_done,
    input logic              busy,
    input logic              adv_time,
    input logic              periodic_tick,
    input logic [BYTE_W-1:0] reg_cfg,
    input logic [BYTE_W-1:0] reg_mode,
    input logic [BYTE_W-1:0] reg_flags,
    input logic              irq
);

    // R3: the host cannot move the busy bit
    a_r3_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && !upd_start && !upd_done) |=> reg_cfg[CFG_BUSY] == $past(reg_cfg[CFG_BUSY]));

    // R3: low bits follow the write
    a_r3_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> reg_cfg[CFG_BUSY-1:0] == $past(wdata[CFG_BUSY-1:0]));

    // R4: SET write leaves update enable and busy bit low
    a_r4_set_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && wdata[M_SET]) |=> (!reg_mode[M_UIE] && !reg_cfg[CFG_BUSY]));

    // R5: a flag read with no new event empties flags and line
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && !upd_done && !periodic_tick) |=> (reg_flags == 8'h00 && !irq));

    // R8: update end always leaves the update flag set
    a_r8_update_flag: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> reg_flags[F_UPD]);

    // R9: advance pulse lasts one cycle
    a_r9_single_adv: assert property (@(posedge clk) disable iff (!rst_n)
        adv_time |=> !adv_time);

    // R11: busy bit only inside the update window
    a_r11_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !reg_cfg[CFG_BUSY]);

    // R11: an update started in SET mode never shows busy
    a_r11_set_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_start && reg_mode[M_SET]) |=> !reg_cfg[CFG_BUSY]);

    // R13: the line agrees with the summary flag
    a_r13_line_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq == reg_flags[F_IRQ]);

endmodule

bind cmos_host_regs rtcr_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_cfg        (wr_cfg),
    .wr_mode       (wr_mode),
    .rd_flags      (rd_flags),
    .wdata         (bus_wdata),
    .upd_start     (upd_start),
    .upd_done      (upd_done),
    .busy          (busy),
    .adv_time      (adv_time),
    .periodic_tick (periodic_tick),
    .reg_cfg       (reg_cfg),
    .reg_mode      (reg_mode),
    .reg_flags     (reg_flags),
    .irq           (irq)
);

// File: tb/tb_cmos_host_regs.sv
// Bench for cmos_host_regs: directed corner cases plus seeded random
// storage and alarm patterns, with expected values from bench functions.
module tb_cmos_host_regs;

    localparam int CLK_PERIOD = 10;
    localparam int UPD        = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_addr0 = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        sec_tick = 1'b0, periodic_tick = 1'b0;
    logic [55:0] now_fields = '0;
    logic        adv_time, load_time, periodic_en, irq;
    logic [55:0] shadow_time;
    logic [3:0]  rate_code;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmos_host_regs #(.UPD_CYCLES(UPD)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr0(bus_addr0), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sec_tick(sec_tick), .periodic_tick(periodic_tick), .now_fields(now_fields),
        .adv_time(adv_time), .load_time(load_time), .shadow_time(shadow_time),
        .rate_code(rate_code), .periodic_en(periodic_en), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Register number of time field k.
    function automatic int tslot(input int k);
        return (k < 4) ? 2 * k : k + 3;
    endfunction

    // Expected flag byte after an update with alarm enabled.
    function automatic logic [7:0] alarm_flags(input logic [23:0] al, input logic [23:0] nw);
        logic hit = 1'b1;
        for (int k = 0; k < 3; k++) begin
            if (!(al[k*8+6 +: 2] == 2'b11 || al[k*8 +: 8] == nw[k*8 +: 8])) hit = 1'b0;
        end
        return hit ? 8'hB0 : 8'h10;
    endfunction

    task automatic bus_cycle(input logic wr, input logic a0, input logic [7:0] d,
                             output logic [7:0] q);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr0 = a0; bus_wdata = d;
        #1 q = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
        logic [7:0] q;
        bus_cycle(1'b1, 1'b0, idx, q);
        bus_cycle(1'b1, 1'b1, d, q);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] q);
        logic [7:0] t;
        bus_cycle(1'b1, 1'b0, idx, t);
        bus_cycle(1'b0, 1'b1, 8'h00, q);
    endtask

    task automatic pulse_second();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (UPD + 2) @(negedge clk);
    endtask

    task automatic pulse_periodic();
        @(negedge clk); periodic_tick = 1'b1;
        @(negedge clk); periodic_tick = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [7:0] q;
        logic [23:0] al;
        int unsigned seed;
        seed = $urandom(32'h5EED);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6: reset values
        check("R6 irq", irq, 1'b0);
        reg_rd(10, q); check("R6 cfg", q, 8'h26);
        reg_rd(11, q); check("R6 mode", q, 8'h02);
        reg_rd(12, q); check("R6 flags", q, 8'h00);
        reg_rd(13, q); check("R6 stat", q, 8'h80);
        bus_cycle(1'b0, 1'b0, 8'h00, q); check("R1 even read", q, 8'hFF);
        check("R13 en after reset", periodic_en, 1'b0);
        check("R13 rate", rate_code, 4'h6);

        // R1: bit 7 of the register number is dropped
        bus_cycle(1'b1, 1'b0, 8'h8E, q);
        bus_cycle(1'b1, 1'b1, 8'h5A, q);
        reg_rd(8'h0E, q); check("R1 index mask", q, 8'h5A);

        // R2: random plain storage
        for (int i = 0; i < 40; i++) begin
            int idx;
            logic [7:0] d;
            idx = int'($urandom % 128);
            if (idx >= 10 && idx <= 13) idx = idx + 20;
            d = 8'($urandom);
            reg_wr(8'(idx), d);
            model[idx] = d;
        end
        for (int i = 0; i < 128; i++) begin
            if (i < 10 || i > 13) begin
                if (model[i] !== 8'hxx && (i == 14 || i % 5 == 0 || i > 100)) begin
                    reg_rd(8'(i), q); check("R2 storage", q, model[i]);
                end
            end
        end

        // R3: busy bit is read-only
        reg_wr(10, 8'hA6);
        reg_rd(10, q); check("R3 busy kept low", q, 8'h26);

        // R12: time write while running
        reg_wr(2, 8'h45);
        check("R12 load pulse", load_time, 1'b1);
        check("R12 shadow", shadow_time[15:8], 8'h45);
        @(negedge clk); check("R12 pulse one cycle", load_time, 1'b0);

        // R11 and R10: busy window and time copy
        now_fields = {8'h26, 8'h11, 8'h28, 8'h03, 8'h13, 8'h47, 8'h59};
        bus_cycle(1'b1, 1'b0, 8'd10, q);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        check("R9 adv pulse", adv_time, 1'b1);
        bus_cycle(1'b0, 1'b1, 8'h00, q); check("R11 busy early", q, 8'hA6);
        check("R9 adv ended", adv_time, 1'b0);
        bus_cycle(1'b0, 1'b1, 8'h00, q); check("R11 busy last cycle", q, 8'hA6);
        bus_cycle(1'b0, 1'b1, 8'h00, q); check("R11 busy cleared", q, 8'h26);
        for (int k = 0; k < 7; k++) begin
            reg_rd(8'(tslot(k)), q); check("R10 time copy", q, now_fields[k*8 +: 8]);
        end
        check("R12 shadow all", shadow_time, now_fields);
        reg_rd(12, q); check("R8 update flag only", q, 8'h10);
        reg_rd(12, q); check("R5 flags cleared", q, 8'h00);

        // R4 and R10: SET mode
        reg_wr(11, 8'h92);
        reg_rd(11, q); check("R4 uie forced low", q, 8'h82);
        reg_wr(0, 8'h11);
        check("R12 no load in SET", load_time, 1'b0);
        bus_cycle(1'b1, 1'b0, 8'd10, q);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        bus_cycle(1'b0, 1'b1, 8'h00, q); check("R11 no busy in SET", q, 8'h26);
        repeat (UPD) @(negedge clk);
        reg_rd(0, q); check("R10 held in SET", q, 8'h11);
        reg_rd(12, q); check("R8 flag in SET", q, 8'h10);
        reg_wr(11, 8'h02);
        check("R12 load on SET exit", load_time, 1'b1);

        // R5: flag and status registers ignore writes
        reg_wr(12, 8'hFF);
        reg_rd(12, q); check("R5 flags write ignored", q, 8'h00);
        reg_wr(13, 8'h00);
        reg_rd(13, q); check("R5 stat write ignored", q, 8'h80);

        // R9: oscillator field not running
        reg_wr(10, 8'h06);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        check("R9 no adv when stopped", adv_time, 1'b0);
        repeat (UPD + 2) @(negedge clk);
        reg_rd(12, q); check("R9 no update when stopped", q, 8'h00);
        reg_wr(10, 8'h26);

        // R8: update interrupt
        reg_wr(11, 8'h12);
        pulse_second();
        check("R8 irq raised", irq, 1'b1);
        reg_rd(12, q); check("R8 flags", q, 8'h90);
        check("R5 irq lowered", irq, 1'b0);

        // R7: alarm with seeded random patterns
        reg_wr(11, 8'h22);
        for (int i = 0; i < 24; i++) begin
            logic [23:0] nw;
            nw = {8'($urandom % 8'h24), 8'($urandom % 8'h60), 8'($urandom % 8'h60)};
            for (int k = 0; k < 3; k++) begin
                case ($urandom % 3)
                    0:       al[k*8 +: 8] = 8'hC0 | 8'($urandom % 64);
                    1:       al[k*8 +: 8] = nw[k*8 +: 8];
                    default: al[k*8 +: 8] = nw[k*8 +: 8] ^ 8'h01;
                endcase
                reg_wr(8'(2 * k + 1), al[k*8 +: 8]);
            end
            now_fields[23:0] = nw;
            pulse_second();
            check("R7 alarm irq", irq, alarm_flags(al, nw) == 8'hB0);
            reg_rd(12, q); check("R7 alarm flags", q, alarm_flags(al, nw));
        end
        reg_wr(11, 8'h02);
        reg_wr(1, 8'hC0); reg_wr(3, 8'hC0); reg_wr(5, 8'hC0);
        pulse_second();
        reg_rd(12, q); check("R7 alarm disabled", q, 8'h10);

        // R13: periodic strobe and divider controls
        reg_wr(11, 8'h42);
        check("R13 en with pie", periodic_en, 1'b1);
        pulse_periodic();
        check("R13 irq periodic", irq, 1'b1);
        reg_rd(12, q); check("R13 periodic flags", q, 8'hC0);
        reg_wr(11, 8'h02);
        pulse_periodic();
        reg_rd(12, q); check("R13 tick ignored", q, 8'h00);
        check("R13 en off", periodic_en, 1'b0);
        reg_wr(11, 8'h0A);
        check("R13 en with sqw", periodic_en, 1'b1);
        reg_wr(10, 8'h20);
        check("R13 rate zero", periodic_en, 1'b0);
        reg_wr(10, 8'h26);

        // R14: flag read in the same edge as the update end
        reg_wr(11, 8'h52);
        pulse_periodic();
        bus_cycle(1'b1, 1'b0, 8'd12, q);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (2) @(negedge clk);
        bus_cycle(1'b0, 1'b1, 8'h00, q);
        check("R14 read sees old flags", q, 8'hC0);
        check("R14 irq stays high", irq, 1'b1);
        reg_rd(12, q); check("R14 new flags kept", q, 8'h90);
        check("R5 irq low after read", irq, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule